// File: doc/BRIEF.md
# Linked-list descriptor DMA channel

One DMA channel that runs a chain of descriptors held in memory. Software writes the byte address of the first descriptor into the channel's descriptor address register and then sets the start bit. The channel reads each six-word descriptor through a single-cycle memory read port, copies the described data one beat per cycle, and then follows the descriptor's next pointer. A special next-pointer value ends the chain. A chain whose last pointer leads back to its first descriptor runs with no end, until software stops it.

While a descriptor is running, its config, current source, current destination, remaining count and parameter word can all be read back live. The descriptor address register then holds the pointer to the following descriptor, so software can work out how many bytes are still to move. Pause is a bit of its own, separate from enable. The channel emits a one-cycle package-end pulse after every descriptor and a queue-end pulse when the chain terminates.

Top module: `lld_channel`

## Requirements
- R1: The register block sits at 0x100 + 0x40*CHAN_IDX. Word offsets are: 0x00 enable (bit 0), 0x04 pause (bit 1), 0x08 descriptor address, 0x0C config, 0x10 source, 0x14 destination, 0x18 count, 0x1C parameter. An access to any other address, or to an address whose low two bits are not zero, writes nothing and reads 0.
- R2: Writing 1 to enable bit 0 while the channel is idle starts it. The channel fetches six words from the descriptor address, with the low two address bits forced to zero, in this order: config, source, destination, byte length, parameter, next pointer. Each fetch takes one cycle.
- R3: Each beat reads the 32-bit word that holds the source and writes the destination with byte strobes. The beat size comes from config bits 10:9: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Bytes are taken from the lanes given by the source address's low bits and placed in the lanes given by the destination address's low bits. Config bit 5 (source) and bit 21 (destination) select fixed-address mode when 1; when 0 the address advances by the beat size after each beat.
- R4: While a descriptor runs, the count register holds the bytes still to move and drops by the beat size on each beat. The source and destination registers hold the addresses of the next beat.
- R5: When the finished descriptor's next pointer is 0xFFFFF800, the channel raises queue_end for one cycle, in the same cycle as package_end. It clears enable and goes idle, and the descriptor address register reads 0xFFFFF800.
- R6: package_end pulses for one cycle after every descriptor, including one of zero length, which moves no data. The channel then fetches the descriptor at the next pointer, so a circular chain runs without end.
- R7: While pause (0x04 bit 1) is set, the channel makes no memory access and holds all of its state. A beat or fetch in progress on the cycle pause is written still completes. Clearing pause resumes from the same point.
- R8: Writing 0 to enable bit 0 stops the channel at once, with no queue_end. A beat or descriptor end that falls on the same edge as the stop still completes.
- R9: Software can write the descriptor address only while the channel is idle; a write while it is running is ignored. The config, source, destination, count and parameter registers are read-only.
- R10: After reset, every register reads 0, and no memory access or event pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Word-aligned memory read address |
| mem_rd_data | input | 32 | Read data, valid in the same cycle |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | 32 | Word-aligned memory write address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_strb | output | 4 | Byte strobes for the write |
| pkg_end | output | 1 | One-cycle pulse after each descriptor |
| queue_end | output | 1 | One-cycle pulse when the chain ends |

## Verification
The collision that matters most is a pause write landing on the same edge as the final beat of a descriptor. The beat must finish, package_end must still fire, and the fetch of the next descriptor must then be held. The bench counts cycles from the start write so that its pause write takes effect on exactly the edge of the last beat. It then checks that the count reads 0, that the descriptor address reads the second descriptor's address, that one package_end has been seen and that exactly two beats were written. After resume it checks that the second descriptor completes. A second collision, a stop arriving while a circular chain is running, is judged by checking that no queue_end occurs and that memory writes cease.

// File: rtl/lld_pkg.sv
package lld_pkg;

    localparam logic [31:0] LLD_END_PTR = 32'hFFFF_F800;

    // config bit positions the beat datapath decodes
    localparam int CFG_SRC_IO  = 5;
    localparam int CFG_SRC_WLO = 9;
    localparam int CFG_DST_IO  = 21;

    // register word indices inside the channel block
    localparam int RIX_EN    = 0;
    localparam int RIX_PAUSE = 1;
    localparam int RIX_LLI   = 2;
    localparam int RIX_CFG   = 3;
    localparam int RIX_SRC   = 4;
    localparam int RIX_DST   = 5;
    localparam int RIX_CNT   = 6;
    localparam int RIX_PARA  = 7;

    localparam logic [2:0] FETCH_LAST = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2
    } lld_state_e;

    typedef struct packed {
        lld_state_e  st;
        logic [2:0]  widx;
        logic        en;
        logic        pause;
        logic [31:0] lli;
        logic [31:0] fbase;
        logic [31:0] cfg;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] cnt;
        logic [31:0] para;
        logic        pkg;
        logic        qend;
    } lld_regs_t;

    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (code)
            2'd0:    beat_bytes = 3'd1;
            2'd1:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lld_addr_dec.sv
module lld_addr_dec #(
    parameter int REG_AW   = 12,
    parameter int BLK_BASE = 256,
    parameter int STRIDE   = 64,
    parameter int CHAN_IDX = 0,
    parameter int OFS_W    = $clog2(STRIDE),
    parameter int IDX_W    = OFS_W - 2
) (
    input  logic [REG_AW-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  widx
);
    localparam logic [REG_AW-1:0] BLK = REG_AW'(BLK_BASE + STRIDE * CHAN_IDX);

    always_comb begin
        hit  = (addr[REG_AW-1:OFS_W] == BLK[REG_AW-1:OFS_W]) && (addr[1:0] == 2'b00);
        widx = addr[OFS_W-1:2];
    end
endmodule

// File: rtl/lld_beat.sv
module lld_beat
    import lld_pkg::*;
(
    input  logic [1:0]  src_wcode,
    input  logic        src_fixed,
    input  logic        dst_fixed,
    input  logic [31:0] src,
    input  logic [31:0] dst,
    input  logic [31:0] cnt,
    input  logic [31:0] rd_word,
    output logic [31:0] rd_addr,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    output logic [3:0]  wr_strb,
    output logic [31:0] src_nxt,
    output logic [31:0] dst_nxt,
    output logic [31:0] cnt_nxt
);
    logic [2:0]  nbytes;
    logic [31:0] step;
    logic [31:0] lane_aligned;
    logic [3:0]  mask;

    always_comb begin
        nbytes       = beat_bytes(src_wcode);
        step         = {29'd0, nbytes};
        lane_aligned = rd_word >> {src[1:0], 3'b000};
        wr_data      = lane_aligned << {dst[1:0], 3'b000};
        case (nbytes)
            3'd1:    mask = 4'b0001;
            3'd2:    mask = 4'b0011;
            default: mask = 4'b1111;
        endcase
        wr_strb = mask << dst[1:0];
        rd_addr = {src[31:2], 2'b00};
        wr_addr = {dst[31:2], 2'b00};
        src_nxt = src_fixed ? src : src + step;
        dst_nxt = dst_fixed ? dst : dst + step;
        cnt_nxt = (cnt > step) ? cnt - step : 32'd0;
    end
endmodule

// File: rtl/lld_rdmux.sv
module lld_rdmux
    import lld_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             hit,
    input  logic [IDX_W-1:0] widx,
    input  logic             en,
    input  logic             pause,
    input  logic [31:0]      lli,
    input  logic [31:0]      cfg,
    input  logic [31:0]      src,
    input  logic [31:0]      dst,
    input  logic [31:0]      cnt,
    input  logic [31:0]      para,
    output logic [31:0]      rdata
);
    logic [7:0] sel;

    always_comb begin
        sel   = 8'(widx);
        rdata = 32'd0;
        if (hit) begin
            case (sel)
                8'(RIX_EN):    rdata = {31'd0, en};
                8'(RIX_PAUSE): rdata = {30'd0, pause, 1'b0};
                8'(RIX_LLI):   rdata = lli;
                8'(RIX_CFG):   rdata = cfg;
                8'(RIX_SRC):   rdata = src;
                8'(RIX_DST):   rdata = dst;
                8'(RIX_CNT):   rdata = cnt;
                8'(RIX_PARA):  rdata = para;
                default:       rdata = 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/lld_channel.sv
module lld_channel
    import lld_pkg::*;
#(
    parameter int REG_AW     = 12,
    parameter int BLK_BASE   = 256,
    parameter int BLK_STRIDE = 64,
    parameter int CHAN_IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd_en,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [31:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [3:0]        mem_wr_strb,
    output logic              pkg_end,
    output logic              queue_end
);
    localparam int OFS_W = $clog2(BLK_STRIDE);
    localparam int IDX_W = OFS_W - 2;

    lld_regs_t q, d;

    logic             reg_hit;
    logic [IDX_W-1:0] reg_widx;
    logic [7:0]       wsel;
    logic             rd_en;
    logic [31:0]      rd_addr;
    logic             wr_en;
    logic             desc_done;
    logic [31:0]      nxt_ptr;
    logic [31:0]      bt_rd_addr, bt_src_nxt, bt_dst_nxt, bt_cnt_nxt;

    // probes for the bound checker
    logic        chk_en, chk_pause;
    logic [31:0] chk_cnt;

    lld_addr_dec #(
        .REG_AW(REG_AW), .BLK_BASE(BLK_BASE), .STRIDE(BLK_STRIDE),
        .CHAN_IDX(CHAN_IDX), .OFS_W(OFS_W), .IDX_W(IDX_W)
    ) dec_i (
        .addr(reg_addr), .hit(reg_hit), .widx(reg_widx)
    );

    lld_beat beat_i (
        .src_wcode(q.cfg[CFG_SRC_WLO+1:CFG_SRC_WLO]),
        .src_fixed(q.cfg[CFG_SRC_IO]),
        .dst_fixed(q.cfg[CFG_DST_IO]),
        .src(q.src), .dst(q.dst), .cnt(q.cnt),
        .rd_word(mem_rd_data),
        .rd_addr(bt_rd_addr), .wr_addr(mem_wr_addr),
        .wr_data(mem_wr_data), .wr_strb(mem_wr_strb),
        .src_nxt(bt_src_nxt), .dst_nxt(bt_dst_nxt), .cnt_nxt(bt_cnt_nxt)
    );

    lld_rdmux #(.IDX_W(IDX_W)) rdmux_i (
        .hit(reg_hit), .widx(reg_widx),
        .en(q.en), .pause(q.pause), .lli(q.lli), .cfg(q.cfg),
        .src(q.src), .dst(q.dst), .cnt(q.cnt), .para(q.para),
        .rdata(reg_rdata)
    );

    always_comb begin
        d         = q;
        d.pkg     = 1'b0;
        d.qend    = 1'b0;
        rd_en     = 1'b0;
        rd_addr   = 32'd0;
        wr_en     = 1'b0;
        desc_done = 1'b0;
        nxt_ptr   = q.lli;
        wsel      = 8'(reg_widx);

        unique case (q.st)
            ST_FETCH: begin
                if (!q.pause) begin
                    rd_en   = 1'b1;
                    rd_addr = q.fbase + {27'd0, q.widx, 2'b00};
                    case (q.widx)
                        3'd0: d.cfg  = mem_rd_data;
                        3'd1: d.src  = mem_rd_data;
                        3'd2: d.dst  = mem_rd_data;
                        3'd3: d.cnt  = mem_rd_data;
                        3'd4: d.para = mem_rd_data;
                        default: begin
                            d.lli   = mem_rd_data;
                            nxt_ptr = mem_rd_data;
                            if (q.cnt == 32'd0) desc_done = 1'b1;
                            else                d.st      = ST_MOVE;
                        end
                    endcase
                    d.widx = (q.widx == FETCH_LAST) ? 3'd0 : q.widx + 3'd1;
                end
            end
            ST_MOVE: begin
                if (!q.pause) begin
                    rd_en   = 1'b1;
                    rd_addr = bt_rd_addr;
                    wr_en   = 1'b1;
                    d.src   = bt_src_nxt;
                    d.dst   = bt_dst_nxt;
                    d.cnt   = bt_cnt_nxt;
                    if (bt_cnt_nxt == 32'd0) desc_done = 1'b1;
                end
            end
            default: ;
        endcase

        if (desc_done) begin
            d.pkg = 1'b1;
            if (nxt_ptr == LLD_END_PTR) begin
                d.qend = 1'b1;
                d.en   = 1'b0;
                d.st   = ST_IDLE;
            end else begin
                d.fbase = {nxt_ptr[31:2], 2'b00};
                d.widx  = 3'd0;
                d.st    = ST_FETCH;
            end
        end

        if (reg_hit && reg_we) begin
            case (wsel)
                8'(RIX_EN): begin
                    if (!reg_wdata[0]) begin
                        d.en = 1'b0;
                        d.st = ST_IDLE;
                    end else if (!q.en) begin
                        d.en    = 1'b1;
                        d.st    = ST_FETCH;
                        d.widx  = 3'd0;
                        d.fbase = {q.lli[31:2], 2'b00};
                    end
                end
                8'(RIX_PAUSE): d.pause = reg_wdata[1];
                8'(RIX_LLI):   if (!q.en) d.lli = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd_en   = rd_en;
    assign mem_rd_addr = rd_addr;
    assign mem_wr_en   = wr_en;
    assign pkg_end     = q.pkg;
    assign queue_end   = q.qend;
    assign chk_en      = q.en;
    assign chk_pause   = q.pause;
    assign chk_cnt     = q.cnt;

endmodule

// File: rtl/lld_channel_chk.sv
module lld_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic        pkg_end,
    input logic        queue_end,
    input logic        en_q,
    input logic        pause_q,
    input logic [31:0] cnt_q
);
    assert_qend_with_pkg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        queue_end |-> pkg_end);

    assert_qend_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        queue_end |-> !en_q);

    assert_beat_shrinks_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (cnt_q < $past(cnt_q)));

    assert_pause_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_q && $past(pause_q)) |-> $stable(cnt_q));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!mem_rd_en && !mem_wr_en));
endmodule

bind lld_channel lld_channel_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .pkg_end(pkg_end), .queue_end(queue_end),
    .en_q(chk_en), .pause_q(chk_pause), .cnt_q(chk_cnt)
);

// File: tb/lld_channel_tb_top.sv
`timescale 1ns/1ps
module lld_channel_tb_top;
    localparam logic [11:0] B = 12'h140;   // channel 1 block
    localparam logic [31:0] ENDP = 32'hFFFF_F800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = 12'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_strb;
    logic        pkg_end, queue_end;

    logic [7:0] bmem [0:1023];
    logic [7:0] emem [0:1023];
    int total = 0, bad = 0, cyc = 0;
    int pkg_cnt = 0, qend_cnt = 0, wr_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lld_channel #(.CHAN_IDX(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_strb(mem_wr_strb), .pkg_end(pkg_end), .queue_end(queue_end)
    );

    always_comb mem_rd_data = {bmem[{mem_rd_addr[9:2], 2'b11}], bmem[{mem_rd_addr[9:2], 2'b10}],
                               bmem[{mem_rd_addr[9:2], 2'b01}], bmem[{mem_rd_addr[9:2], 2'b00}]};

    always @(posedge clk) begin
        if (mem_wr_en) begin
            wr_cnt <= wr_cnt + 1;
            for (int j = 0; j < 4; j++)
                if (mem_wr_strb[j]) bmem[{mem_wr_addr[9:2], 2'(j)}] <= mem_wr_data[8*j +: 8];
        end
        if (pkg_end)   pkg_cnt  <= pkg_cnt + 1;
        if (queue_end) qend_cnt <= qend_cnt + 1;
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            total = total + 1; bad = bad + 1;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic put_w(input int a, input logic [31:0] v);
        for (int j = 0; j < 4; j++) bmem[a + j] = v[8*j +: 8];
    endtask

    task automatic put_desc(input int a, input logic [31:0] cfg, src, dst, len, nxt);
        put_w(a, cfg); put_w(a + 4, src); put_w(a + 8, dst);
        put_w(a + 12, len); put_w(a + 16, 32'h0000_0001); put_w(a + 20, nxt);
    endtask

    task automatic wait_qend(input int q0, input string tag);
        int t = 0;
        while (qend_cnt == q0 && t < 3000) begin @(negedge clk); t++; end
        chk(qend_cnt == q0 + 1, tag, 32'(qend_cnt - q0), 32'd1);
    endtask

    function automatic logic [31:0] mk_cfg(input int w, input int sio, input int dio);
        return (32'(w) << 9) | (32'(sio) << 5) | (32'(w) << 25) | (32'(dio) << 21);
    endfunction

    task automatic run_combo(input int w, input int sio, input int dio, input int seq);
        int nb = 1 << w;
        int soff = (w == 0) ? 1 : ((w == 1) ? 2 : 0);
        int doff = (w == 0) ? 3 : 0;
        int src = 32'h200 + soff, dst = 32'h300 + doff;
        int nbeats = 8 / nb;
        int mism = 0, p0 = pkg_cnt, q0 = qend_cnt;
        logic [31:0] v;
        for (int i = 32'h300; i < 32'h340; i++) begin bmem[i] = 8'hEE; emem[i] = 8'hEE; end
        for (int k = 0; k < nbeats; k++) begin
            int s = src + (sio != 0 ? 0 : k * nb);
            int dd = dst + (dio != 0 ? 0 : k * nb);
            for (int j = 0; j < nb; j++) emem[dd + j] = bmem[s + j];
        end
        put_desc(32'h40, mk_cfg(w, sio, dio), 32'(src), 32'(dst), 32'd8, ENDP);
        reg_wr(B + 12'h08, 32'h40 | 32'(seq & 3));   // R2: low bits ignored
        reg_wr(B + 12'h00, 32'd1);
        wait_qend(q0, "R5 combo queue end");
        repeat (2) @(negedge clk);
        for (int i = 32'h300; i < 32'h340; i++) if (bmem[i] != emem[i]) mism++;
        chk(mism == 0, $sformatf("R3 w=%0d sio=%0d dio=%0d byte mismatches", w, sio, dio),
            32'(mism), 32'd0);
        chk(pkg_cnt == p0 + 1, "R6 one package end", 32'(pkg_cnt - p0), 32'd1);
        reg_rd(B + 12'h08, v);
        chk(v == ENDP, "R5 lli reads end marker", v, ENDP);
    endtask

    initial begin
        logic [31:0] v, c1, c2;
        int p0, q0, w0, mism, t;
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        for (int i = 32'h200; i < 32'h280; i++) bmem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int o = 0; o < 8; o++) begin
            reg_rd(B + 12'(o * 4), v);
            chk(v == 32'd0, $sformatf("R10 reg %0d after reset", o), v, 32'd0);
        end
        chk(pkg_cnt == 0 && qend_cnt == 0 && wr_cnt == 0, "R10 no activity", 32'(wr_cnt), 32'd0);

        // R1: channel 0 block and misaligned addresses do not reach this channel
        reg_wr(12'h108, 32'h55);
        reg_wr(12'h100, 32'd1);
        reg_wr(B + 12'h0A, 32'h77);
        reg_rd(B + 12'h08, v);
        chk(v == 32'd0, "R1 foreign writes ignored", v, 32'd0);
        reg_rd(B + 12'h00, v);
        chk(v == 32'd0, "R1 enable untouched", v, 32'd0);
        reg_rd(12'h108, v);
        chk(v == 32'd0, "R1 foreign read zero", v, 32'd0);
        reg_wr(B + 12'h08, 32'h44);
        reg_rd(B + 12'h08, v);
        chk(v == 32'h44, "R9 lli writable while idle", v, 32'h44);

        // R3/R2: sweep width x source mode x destination mode
        for (int w = 0; w < 3; w++)
            for (int sio = 0; sio < 2; sio++)
                for (int dio = 0; dio < 2; dio++)
                    run_combo(w, sio, dio, w * 4 + sio * 2 + dio);

        // R7/R4/R9: pause in the middle of a 32-beat descriptor
        for (int i = 32'h300; i < 32'h340; i++) bmem[i] = 8'h00;
        put_desc(32'h60, mk_cfg(0, 0, 0), 32'h200, 32'h300, 32'd32, ENDP);
        q0 = qend_cnt; w0 = wr_cnt;
        reg_wr(B + 12'h08, 32'h60);
        reg_wr(B + 12'h00, 32'd1);
        repeat (12) @(negedge clk);
        reg_wr(B + 12'h04, 32'h2);
        repeat (3) @(negedge clk);
        reg_rd(B + 12'h18, c1);
        repeat (10) @(negedge clk);
        reg_rd(B + 12'h18, c2);
        chk(c1 == c2, "R7 count frozen while paused", c2, c1);
        chk(c1 > 0 && c1 < 32, "R4 count mid-run", c1, 32'd16);
        chk(32'(wr_cnt - w0) == 32'd32 - c1, "R4 beats equal bytes moved", 32'(wr_cnt - w0), 32'd32 - c1);
        reg_rd(B + 12'h10, v);
        chk(v == 32'h200 + (32'd32 - c1), "R4 live source", v, 32'h200 + (32'd32 - c1));
        reg_rd(B + 12'h08, v);
        chk(v == ENDP, "R4 lli holds next pointer", v, ENDP);
        reg_wr(B + 12'h08, 32'h123);
        reg_wr(B + 12'h18, 32'h9);
        reg_rd(B + 12'h08, v);
        chk(v == ENDP, "R9 lli write ignored while running", v, ENDP);
        reg_rd(B + 12'h18, v);
        chk(v == c1, "R9 count read-only", v, c1);
        reg_wr(B + 12'h04, 32'h0);
        wait_qend(q0, "R7 resume completes");
        mism = 0;
        for (int i = 0; i < 32; i++) if (bmem[32'h300 + i] != bmem[32'h200 + i]) mism++;
        chk(mism == 0, "R7 data complete after resume", 32'(mism), 32'd0);

        // R7/R6: pause lands on the edge of the last beat of descriptor 1
        put_desc(32'h80, mk_cfg(2, 0, 0), 32'h220, 32'h340, 32'd8, 32'hA0);
        put_desc(32'hA0, mk_cfg(2, 0, 0), 32'h230, 32'h350, 32'd4, ENDP);
        p0 = pkg_cnt; q0 = qend_cnt; w0 = wr_cnt;
        reg_wr(B + 12'h08, 32'h80);
        reg_wr(B + 12'h00, 32'd1);
        repeat (7) @(negedge clk);
        reg_wr(B + 12'h04, 32'h2);
        repeat (10) @(negedge clk);
        chk(pkg_cnt == p0 + 1, "R7 package end still fires", 32'(pkg_cnt - p0), 32'd1);
        chk(wr_cnt == w0 + 2, "R7 final beat completed", 32'(wr_cnt - w0), 32'd2);
        reg_rd(B + 12'h18, v);
        chk(v == 32'd0, "R4 count zero at boundary", v, 32'd0);
        reg_rd(B + 12'h08, v);
        chk(v == 32'hA0, "R6 lli points to next descriptor", v, 32'hA0);
        reg_rd(B + 12'h10, v);
        chk(v == 32'h228, "R4 source advanced", v, 32'h228);
        reg_wr(B + 12'h04, 32'h0);
        wait_qend(q0, "R6 chain of two ends");
        chk(pkg_cnt == p0 + 2, "R6 two package ends", 32'(pkg_cnt - p0), 32'd2);
        reg_rd(B + 12'h00, v);
        chk(v == 32'd0, "R5 enable cleared", v, 32'd0);

        // R6: zero-length descriptor
        put_desc(32'hC0, mk_cfg(2, 0, 0), 32'h200, 32'h360, 32'd0, ENDP);
        p0 = pkg_cnt; q0 = qend_cnt; w0 = wr_cnt;
        reg_wr(B + 12'h08, 32'hC0);
        reg_wr(B + 12'h00, 32'd1);
        wait_qend(q0, "R6 zero-length ends");
        chk(pkg_cnt == p0 + 1 && wr_cnt == w0, "R6 zero-length no writes", 32'(wr_cnt - w0), 32'd0);

        // R6/R8: circular chain, then stop
        put_desc(32'h00, mk_cfg(2, 0, 0), 32'h200, 32'h380, 32'd4, 32'h20);
        put_desc(32'h20, mk_cfg(2, 0, 0), 32'h204, 32'h384, 32'd4, 32'h00);
        p0 = pkg_cnt; q0 = qend_cnt;
        reg_wr(B + 12'h08, 32'h00);
        reg_wr(B + 12'h00, 32'd1);
        t = 0;
        while (pkg_cnt - p0 < 5 && t < 2000) begin @(negedge clk); t++; end
        chk(pkg_cnt - p0 >= 5, "R6 circular chain keeps running", 32'(pkg_cnt - p0), 32'd5);
        reg_wr(B + 12'h00, 32'd0);
        reg_wr(B + 12'h04, 32'd0);
        reg_rd(B + 12'h00, v);
        chk(v == 32'd0, "R8 stopped", v, 32'd0);
        w0 = wr_cnt; p0 = pkg_cnt;
        repeat (20) @(negedge clk);
        chk(wr_cnt == w0 && pkg_cnt == p0, "R8 no activity after stop", 32'(wr_cnt - w0), 32'd0);
        chk(qend_cnt == q0, "R8 no queue end on stop", 32'(qend_cnt - q0), 32'd0);
        reg_rd(B + 12'h04, v);
        chk(v == 32'd0, "R8 unpaused after stop", v, 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule